// File: doc/BRIEF.md
# Flash Program and Erase Engine

This block carries out the write-side operations of a small byte-wide non-volatile array: byte program, whole-array erase and a one-way lock of a boot region. The array is a parameterised bank of bytes. Real program and erase durations are replaced by cycle counts. Each accepted command arrives as a one-cycle pulse that carries an operation code, an address and a data byte. Command-sequence decoding and the external bus protocol belong to the surrounding logic.

While an operation runs, the `busy` flag is high. Reads during that time return status bits instead of plain array contents, so software can poll for completion. Bit 7 is a completion indicator and bit 6 flips on every read. A separate identification mode returns fixed codes and the lock state.

The boot region spans 2^BOOT_W bytes. It sits either at the bottom or at the top of the address space, selected by a parameter. After the lock command, program and erase leave that region untouched. The rest of the array stays writable.

Top module: `flash_eng`

## Requirements
- R1: After reset, `busy` is 0, every byte reads FFh, and the lock status reads 0.
- R2: A program command (`cmd_op`=1) leaves `busy` high for exactly PROG_CYCLES cycles after the accepting edge. After that, the addressed byte equals its old value ANDed with the command data, so bits only go from 1 to 0.
- R3: An erase command (`cmd_op`=2) leaves `busy` high for exactly ERASE_CYCLES cycles. After that, every byte outside a locked boot region reads FFh.
- R4: With BOOT_TOP=0, the boot region is addresses 0 to 2^BOOT_W-1. With BOOT_TOP=1, it is the top 2^BOOT_W addresses. Addresses outside it are main region and are never affected by the lock.
- R5: The lock command (`cmd_op`=3) sets a lock that no command clears. A program command aimed at a locked boot byte never raises `busy` and leaves the byte unchanged.
- R6: An erase issued while the lock is set leaves every boot byte unchanged.
- R7: While a program runs, a read of its address returns the inverse of data bit 7 of the command on `rd_data[7]`. Reads of other addresses return the stored bit 7. While an erase runs, `rd_data[7]` is 0. Bits 5:0 return the stored byte. Once `busy` falls, reads return true stored data.
- R8: During an operation, the first read returns 0 on `rd_data[6]`. Each further read during that same operation returns the opposite value from the read before it.
- R9: Identification mode is entered with `cmd_op`=4 and left with `cmd_op`=5. In this mode, when idle, address 0 returns MFR_CODE, address 1 returns DEV_CODE, address 2 returns the lock on bit 0 (1 = locked), and any other address returns 00h. After exit, reads return array data again.
- R10: Any command presented while `busy` is high is ignored. It changes neither the array, the lock nor the mode.
- R11: Read data appears on `rd_data` on the clock edge that samples `rd_valid`, and is held until the next read.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | 1 program, 2 erase, 3 lock, 4 ID mode on, 5 ID mode off |
| cmd_addr | input | ADDR_W | Command byte address |
| cmd_data | input | 8 | Command data byte |
| rd_valid | input | 1 | Read request strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read result |
| busy | output | 1 | Program or erase in progress |

## Verification
The hardest situations to reach are the ones that only exist inside the timed window of an operation. These include the inverted bit 7, the alternating bit 6 and a command arriving while `busy` is high.

The stimulus issues a program command and then packs several reads and a stray program command into the cycles before completion. It repeats this for an erase, this time with a stray identification-mode command. Each operation runs long enough that all of these fall inside the busy window.

The locked boot case is reached by programming a boot byte first, then locking. After that come a program attempt on the last boot address, one on the first main address, and an erase. This shows the region edge and that the erase spares the region.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;

    localparam int DATA_W = 8;

    typedef logic [DATA_W-1:0] byte_t;

    localparam byte_t ERASED_BYTE = '1;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_LOCK   = 3'd3,
        OP_ID_ON  = 3'd4,
        OP_ID_OFF = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        JOB_IDLE  = 2'd0,
        JOB_PROG  = 2'd1,
        JOB_ERASE = 2'd2
    } job_e;

    typedef struct packed {
        job_e  kind;
        byte_t data;
    } job_t;

    // programming can only pull bits toward zero
    function automatic byte_t prog_merge(byte_t old_b, byte_t new_b);
        return old_b & new_b;
    endfunction

    function automatic byte_t status_byte(byte_t stored, logic poll7, logic tog6);
        return {poll7, tog6, stored[5:0]};
    endfunction

endpackage

// File: rtl/flash_eng_timer.sv
module flash_eng_timer
    import flash_eng_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int PROG_CYCLES  = 12,
    parameter int ERASE_CYCLES = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  job_e              start_kind,
    input  logic [ADDR_W-1:0] start_addr,
    input  byte_t             start_data,
    output logic              busy,
    output logic              done,
    output job_t              job,
    output logic [ADDR_W-1:0] job_addr
);

    localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic [CNT_W-1:0] cnt_q;

    assign done = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            cnt_q    <= '0;
            job      <= '{kind: JOB_IDLE, data: '0};
            job_addr <= '0;
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy     <= 1'b0;
                job.kind <= JOB_IDLE;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (start) begin
            busy     <= 1'b1;
            cnt_q    <= (start_kind == JOB_PROG) ? CNT_W'(PROG_CYCLES - 1)
                                                 : CNT_W'(ERASE_CYCLES - 1);
            job      <= '{kind: start_kind, data: start_data};
            job_addr <= start_addr;
        end
    end

    // R10: a running job keeps its target while it counts down
    p_job_held_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && $stable(job_addr) && $stable(job)));

    // R2: the job ends right after its final cycle
    p_done_ends_r2: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    p_start_kind_r3: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |-> (start_kind != JOB_IDLE));

endmodule

// File: rtl/flash_eng_array.sv
module flash_eng_array
    import flash_eng_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int BOOT_W   = 4,
    parameter bit BOOT_TOP = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  byte_t             prog_data,
    input  logic              erase_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output byte_t             rd_byte,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              chk_boot
);

    localparam int DEPTH     = 1 << ADDR_W;
    localparam int BOOT_SIZE = 1 << BOOT_W;
    localparam int BOOT_IDX  = BOOT_TOP ? DEPTH - 1 : 0;
    localparam int MAIN_IDX  = BOOT_TOP ? 0 : DEPTH - 1;

    byte_t mem [DEPTH];
    logic  prog_boot;

    function automatic logic idx_in_boot(int idx);
        if (BOOT_TOP) return idx >= DEPTH - BOOT_SIZE;
        else          return idx < BOOT_SIZE;
    endfunction

    generate
        if (BOOT_TOP) begin : g_boot_high
            assign chk_boot  = &chk_addr[ADDR_W-1:BOOT_W];
            assign prog_boot = &prog_addr[ADDR_W-1:BOOT_W];
        end else begin : g_boot_low
            assign chk_boot  = ~|chk_addr[ADDR_W-1:BOOT_W];
            assign prog_boot = ~|prog_addr[ADDR_W-1:BOOT_W];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (erase_en) begin
                    if (!(lock && idx_in_boot(i))) mem[i] <= ERASED_BYTE;
                end else if (prog_en && (prog_addr == ADDR_W'(i))) begin
                    mem[i] <= prog_merge(mem[i], prog_data);
                end
            end
        end
    end

    assign rd_byte = mem[rd_addr];

    // R5: the engine never commits a program into a locked boot byte
    p_no_locked_prog_r5: assert property (@(posedge clk) disable iff (rst)
        prog_en |-> !(lock && prog_boot));

    // R2: a program never raises a bit
    p_prog_clears_only_r2: assert property (@(posedge clk) disable iff (rst)
        (prog_en && !erase_en) |=>
            ((mem[$past(prog_addr)] & ~$past(mem[prog_addr])) == '0));

    // R3: a main-region byte is erased
    p_erase_main_r3: assert property (@(posedge clk) disable iff (rst)
        erase_en |=> (mem[MAIN_IDX] == ERASED_BYTE));

    // R6: a locked boot byte survives erase
    p_erase_spares_r6: assert property (@(posedge clk) disable iff (rst)
        (erase_en && lock) |=> (mem[BOOT_IDX] == $past(mem[BOOT_IDX])));

endmodule

// File: rtl/flash_eng_rdpath.sv
module flash_eng_rdpath
    import flash_eng_pkg::*;
#(
    parameter int    ADDR_W   = 8,
    parameter byte_t MFR_CODE = 8'h5A,
    parameter byte_t DEV_CODE = 8'hC3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  byte_t             stored,
    input  logic              busy,
    input  logic              done,
    input  job_t              job,
    input  logic [ADDR_W-1:0] job_addr,
    input  logic              id_mode,
    input  logic              lock,
    output byte_t             rd_data
);

    localparam logic [ADDR_W-1:0] ID_MFR_A  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ID_DEV_A  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ID_LOCK_A = ADDR_W'(2);

    logic  tog_q;
    logic  poll7;
    byte_t id_byte;
    byte_t next_rd;

    always_comb begin
        if (job.kind == JOB_PROG)
            poll7 = (rd_addr == job_addr) ? ~job.data[7] : stored[7];
        else
            poll7 = 1'b0;
    end

    always_comb begin
        unique case (rd_addr)
            ID_MFR_A:  id_byte = MFR_CODE;
            ID_DEV_A:  id_byte = DEV_CODE;
            ID_LOCK_A: id_byte = {7'b0, lock};
            default:   id_byte = '0;
        endcase
    end

    always_comb begin
        if (busy)         next_rd = status_byte(stored, poll7, tog_q);
        else if (id_mode) next_rd = id_byte;
        else              next_rd = stored;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            tog_q   <= 1'b0;
        end else begin
            if (rd_valid) rd_data <= next_rd;
            if (done)                  tog_q <= 1'b0;
            else if (busy && rd_valid) tog_q <= ~tog_q;
        end
    end

    // R8: back-to-back busy reads see bit 6 alternate
    p_toggle_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && busy && !done && $past(rd_valid && busy && !done))
            |=> (rd_data[6] != $past(rd_data[6])));

    // R11: the read result only moves when a read is requested
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |=> $stable(rd_data));

    // R7: erase status carries a zero in bit 7
    p_erase_poll_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && busy && job.kind == JOB_ERASE) |=> !rd_data[7]);

endmodule

// File: rtl/flash_eng.sv
module flash_eng
    import flash_eng_pkg::*;
#(
    parameter int    ADDR_W       = 8,
    parameter int    BOOT_W       = 4,
    parameter bit    BOOT_TOP     = 1'b0,
    parameter int    PROG_CYCLES  = 12,
    parameter int    ERASE_CYCLES = 40,
    parameter byte_t MFR_CODE     = 8'h5A,
    parameter byte_t DEV_CODE     = 8'hC3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);

    op_e               op;
    logic              accept;
    logic              cmd_boot;
    logic              start;
    job_e              start_kind;
    logic              lock_q;
    logic              id_q;
    logic              done;
    job_t              job;
    logic [ADDR_W-1:0] job_addr;
    byte_t             stored;
    logic              prog_en;
    logic              erase_en;

    assign op     = op_e'(cmd_op);
    assign accept = cmd_valid && !busy;

    always_comb begin
        start      = 1'b0;
        start_kind = JOB_IDLE;
        if (accept) begin
            if (op == OP_PROG && !(lock_q && cmd_boot)) begin
                start      = 1'b1;
                start_kind = JOB_PROG;
            end else if (op == OP_ERASE) begin
                start      = 1'b1;
                start_kind = JOB_ERASE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            id_q   <= 1'b0;
        end else if (accept) begin
            if (op == OP_LOCK)   lock_q <= 1'b1;
            if (op == OP_ID_ON)  id_q   <= 1'b1;
            if (op == OP_ID_OFF) id_q   <= 1'b0;
        end
    end

    assign prog_en  = done && (job.kind == JOB_PROG);
    assign erase_en = done && (job.kind == JOB_ERASE);

    flash_eng_timer #(
        .ADDR_W      (ADDR_W),
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_CYCLES(ERASE_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .start_kind(start_kind),
        .start_addr(cmd_addr),
        .start_data(cmd_data),
        .busy      (busy),
        .done      (done),
        .job       (job),
        .job_addr  (job_addr)
    );

    flash_eng_array #(
        .ADDR_W  (ADDR_W),
        .BOOT_W  (BOOT_W),
        .BOOT_TOP(BOOT_TOP)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .lock     (lock_q),
        .prog_en  (prog_en),
        .prog_addr(job_addr),
        .prog_data(job.data),
        .erase_en (erase_en),
        .rd_addr  (rd_addr),
        .rd_byte  (stored),
        .chk_addr (cmd_addr),
        .chk_boot (cmd_boot)
    );

    flash_eng_rdpath #(
        .ADDR_W  (ADDR_W),
        .MFR_CODE(MFR_CODE),
        .DEV_CODE(DEV_CODE)
    ) u_rdpath (
        .clk     (clk),
        .rst     (rst),
        .rd_valid(rd_valid),
        .rd_addr (rd_addr),
        .stored  (stored),
        .busy    (busy),
        .done    (done),
        .job     (job),
        .job_addr(job_addr),
        .id_mode (id_q),
        .lock    (lock_q),
        .rd_data (rd_data)
    );

    // R5: once set, the lock stays set
    p_lock_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q);

    // R10: commands seen while busy leave lock and mode alone
    p_ignore_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid) |=> ($stable(lock_q) && $stable(id_q)));

    // R5/R4: a locked boot program never starts a timed job
    p_locked_no_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (accept && op == OP_PROG && lock_q && cmd_boot) |=> !busy);

endmodule

// File: tb/flash_eng_bench.sv
`timescale 1ns/1ps
module flash_eng_bench;

    localparam int ADDR_W = 8;
    localparam int PROG_C = 12;
    localparam int ERASE_C = 30;
    localparam logic [7:0] MFR = 8'h5A;
    localparam logic [7:0] DEV = 8'hC3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0]        cmd_data = '0;
    logic              rd_valid = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;
    logic              busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    flash_eng #(
        .ADDR_W(ADDR_W), .BOOT_W(4), .BOOT_TOP(1'b0),
        .PROG_CYCLES(PROG_C), .ERASE_CYCLES(ERASE_C),
        .MFR_CODE(MFR), .DEV_CODE(DEV)
    ) u_flash_eng (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_valid(rd_valid),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: results appear on the edge after the read was driven
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(it.tag, int'(rd_data), int'(it.exp));
            end
        end
    end

    task automatic do_read(input logic [ADDR_W-1:0] a, input logic [7:0] exp,
                           input string tag);
        sb_item_t it;
        @(negedge clk);
        rd_valid = 1'b1;
        rd_addr  = a;
        it.exp   = exp;
        it.tag   = tag;
        sb_q.push_back(it);
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                          input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = a;
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 busy after reset", int'(busy), 0);
        do_read(8'h20, 8'hFF, "R1 main byte erased");
        do_read(8'h03, 8'hFF, "R1 boot byte erased");

        // R9 identification mode
        do_cmd(3'd4, '0, '0);
        do_read(8'h00, MFR, "R9 manufacturer code");
        do_read(8'h01, DEV, "R9 device code");
        do_read(8'h02, 8'h00, "R1 lock clear at reset");
        do_read(8'h07, 8'h00, "R9 other id address");
        do_cmd(3'd5, '0, '0);
        do_read(8'h00, 8'hFF, "R9 exit returns array");

        // R2 program timing and AND merge
        do_cmd(3'd1, 8'h20, 8'hA5);
        wait_idle(n);
        check("R2 program busy cycles", n, PROG_C);
        do_read(8'h20, 8'hA5, "R2 first program");
        do_cmd(3'd1, 8'h20, 8'h3C);
        wait_idle(n);
        do_read(8'h20, 8'h24, "R2 and merge");

        // R3 erase timing
        do_cmd(3'd2, '0, '0);
        wait_idle(n);
        check("R3 erase busy cycles", n, ERASE_C);
        do_read(8'h20, 8'hFF, "R3 erased main");
        do_cmd(3'd1, 8'h20, 8'h24);
        wait_idle(n);

        // R7 R8 R10 status during program
        do_cmd(3'd1, 8'h30, 8'h12);
        do_read(8'h30, 8'hBF, "R7 poll loaded addr");
        do_read(8'h30, 8'hFF, "R8 toggle second read");
        do_cmd(3'd1, 8'h40, 8'h00);
        do_read(8'h20, 8'h24, "R7 other addr bit7");
        check("R7 still busy", int'(busy), 1);
        wait_idle(n);
        do_read(8'h30, 8'h12, "R7 true data after done");
        do_read(8'h40, 8'hFF, "R10 program while busy ignored");

        // R4 boot writable before lock, then R5 lock
        do_cmd(3'd1, 8'h05, 8'h0F);
        wait_idle(n);
        do_read(8'h05, 8'h0F, "R4 boot programmable unlocked");
        do_cmd(3'd3, '0, '0);
        do_cmd(3'd4, '0, '0);
        do_read(8'h02, 8'h01, "R9 lock bit reported");
        do_cmd(3'd5, '0, '0);
        do_cmd(3'd1, 8'h0F, 8'h00);
        check("R5 locked program no busy", int'(busy), 0);
        do_read(8'h0F, 8'hFF, "R5 locked byte unchanged");
        do_cmd(3'd1, 8'h10, 8'h00);
        check("R4 main program busy", int'(busy), 1);
        wait_idle(n);
        do_read(8'h10, 8'h00, "R4 first main byte written");

        // R6 R7 R8 R10 erase under lock
        do_cmd(3'd2, '0, '0);
        do_read(8'h20, 8'h24, "R7 erase poll zero");
        do_read(8'h20, 8'h64, "R8 erase toggle");
        do_cmd(3'd4, '0, '0);
        wait_idle(n);
        do_read(8'h20, 8'hFF, "R3 main erased");
        do_read(8'h10, 8'hFF, "R3 first main erased");
        do_read(8'h05, 8'h0F, "R6 boot spared");
        do_read(8'h00, 8'hFF, "R10 id cmd while busy ignored");
        do_cmd(3'd4, '0, '0);
        do_read(8'h02, 8'h01, "R5 lock persists");
        do_cmd(3'd5, '0, '0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule